// File: doc/BRIEF.md
# Wide Register Dword Write Collector

This block sits between a 32-bit host write port and a register file that mixes 32-bit registers with 128-bit registers and 64-bit memory words. The host can only deliver one dword per write, so a wide target would otherwise be updated piecemeal and observed torn. The collector gathers the dwords of one wide target at a time and hands the register file a single commit strobe carrying the whole value, the target class and its index.

Three kinds of wide target exist. Plain wide registers commit only once all four dwords are held. Memory words commit once both of their dwords are held. Descriptor-pointer registers are write-only and commit whenever their top dword is written; any lower dword that was not supplied arrives as zero. While the collector holds part of one target, writes to the other parts of other targets are dropped and leave the held data alone, so interleaved writers lose writes but never tear a commit. Plain 32-bit registers bypass the collector and are forwarded one cycle after the write.

Top module: `wide_write_collector`

## Requirements
- R1: Addresses count dwords. Narrow register i sits at NARROW_BASE+i; wide register i lane d at WIDE_BASE+4i+d; pointer register i lane d at PTR_BASE+4i+d; memory word i lane d at MEM_BASE+2i+d. Lane 0 is bits 31:0, lane 3 is bits 127:96. A write to any other address produces no strobe and leaves the collector unchanged.
- R2: A write to a narrow register raises nar_we for exactly the following cycle with nar_idx and nar_data equal to the written index and data; it does not touch the collector.
- R3: A wide register commits (cmt_kind 0) in the cycle after the write that supplies the last of its four dwords, in any order, with all 128 bits as written; no strobe appears before that.
- R4: Writing a lane that the collector already holds replaces the held value for that lane.
- R5: A memory word commits (cmt_kind 2) in the cycle after both of its dwords are held, with the data in bits 63:0 and bits 127:64 zero.
- R6: A write to lane 3 of a pointer register commits it (cmt_kind 1) in the next cycle; lanes held for that same register are kept and every lane not held is zero.
- R7: While the collector holds part of one target, a write to a lane other than a pointer top lane of any other target is discarded and the held lanes and target are unchanged, so a later commit of the held target carries only its own data.
- R8: A pointer top-lane write that arrives while the collector holds another target commits {data, 96 zero bits} and leaves the held target and lanes intact.
- R9: After any collector commit the collector is empty and the next write to any wide target is accepted.
- R10: During and right after reset no strobe is raised and the collector is empty.
- R11: cmt_we is high for one cycle per completing write and low in a cycle that follows an idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Host write valid for this cycle |
| wr_addr | input | ADDR_W | Dword address of the write |
| wr_data | input | 32 | Write data |
| nar_we | output | 1 | Narrow register write strobe |
| nar_idx | output | IDX_W | Narrow register index |
| nar_data | output | 32 | Narrow register data |
| cmt_we | output | 1 | Wide commit strobe |
| cmt_kind | output | 2 | Target class: 0 wide, 1 pointer, 2 memory word |
| cmt_idx | output | IDX_W | Index of the committed target within its class |
| cmt_data | output | 128 | Committed value |

## Verification
The bench builds the block with three wide registers, two pointer registers, four memory words and eight narrow registers, and with IDX_W set to 3 so that the narrow range fills the index field exactly. The small counts make every target reachable by random traffic, so foreign writes collide with held partial data often, and the bench's own model checks every cycle that no commit mixes lanes from two targets. Address gaps between the regions give unmapped writes to test as well.

// File: rtl/wdc_pkg.sv
package wdc_pkg;

   typedef enum logic [2:0] {
      TGT_NONE   = 3'd0,
      TGT_NARROW = 3'd1,
      TGT_WIDE   = 3'd2,
      TGT_PTR    = 3'd3,
      TGT_MEM    = 3'd4
   } tgt_kind_e;

   localparam logic [1:0] CK_WIDE = 2'd0;
   localparam logic [1:0] CK_PTR  = 2'd1;
   localparam logic [1:0] CK_MEM  = 2'd2;

   localparam int unsigned LANE_W = 32;
   localparam int unsigned LANES  = 4;

   function automatic logic [1:0] commit_code(input tgt_kind_e k);
      case (k)
         TGT_PTR: commit_code = CK_PTR;
         TGT_MEM: commit_code = CK_MEM;
         default: commit_code = CK_WIDE;
      endcase
   endfunction

   function automatic bit spans_overlap(input int unsigned b0, input int unsigned e0,
                                        input int unsigned b1, input int unsigned e1);
      spans_overlap = (b0 < e1) && (b1 < e0) && (b0 != e0) && (b1 != e1);
   endfunction

endpackage

// File: rtl/wdc_decode.sv
module wdc_decode
   import wdc_pkg::*;
#(
   parameter int unsigned ADDR_W       = 10,
   parameter int unsigned IDX_W        = 4,
   parameter int unsigned NARROW_BASE  = 0,
   parameter int unsigned NARROW_COUNT = 16,
   parameter int unsigned WIDE_BASE    = 64,
   parameter int unsigned WIDE_COUNT   = 4,
   parameter int unsigned PTR_BASE     = 128,
   parameter int unsigned PTR_COUNT    = 4,
   parameter int unsigned MEM_BASE     = 256,
   parameter int unsigned MEM_WORDS    = 8
) (
   input  logic [ADDR_W-1:0] addr,
   output tgt_kind_e         kind,
   output logic [IDX_W-1:0]  idx,
   output logic [1:0]        lane
);

   localparam int unsigned NARROW_END = NARROW_BASE + NARROW_COUNT;
   localparam int unsigned WIDE_END   = WIDE_BASE + LANES * WIDE_COUNT;
   localparam int unsigned PTR_END    = PTR_BASE + LANES * PTR_COUNT;
   localparam int unsigned MEM_END    = MEM_BASE + 2 * MEM_WORDS;

   logic [31:0]      a32;
   logic             nar_hit, wide_hit, ptr_hit, mem_hit;
   logic [IDX_W-1:0] nar_idx, wide_idx, ptr_idx, mem_idx;

   assign a32 = 32'(addr);

   // narrow and four-lane regions are always present
   assign nar_hit  = (a32 >= NARROW_BASE) && (a32 < NARROW_END);
   assign nar_idx  = IDX_W'(a32 - NARROW_BASE);
   assign wide_hit = (a32 >= WIDE_BASE) && (a32 < WIDE_END);
   assign wide_idx = IDX_W'((a32 - WIDE_BASE) >> 2);
   assign ptr_hit  = (a32 >= PTR_BASE) && (a32 < PTR_END);
   assign ptr_idx  = IDX_W'((a32 - PTR_BASE) >> 2);

   // the two-lane memory region may be configured away
   generate
      if (MEM_WORDS > 0) begin : g_mem
         assign mem_hit = (a32 >= MEM_BASE) && (a32 < MEM_END);
         assign mem_idx = IDX_W'((a32 - MEM_BASE) >> 1);
      end else begin : g_no_mem
         assign mem_hit = 1'b0;
         assign mem_idx = '0;
      end
   endgenerate

   always_comb begin
      kind = TGT_NONE;
      idx  = '0;
      lane = 2'd0;
      if (nar_hit) begin
         kind = TGT_NARROW;
         idx  = nar_idx;
      end else if (wide_hit) begin
         kind = TGT_WIDE;
         idx  = wide_idx;
         lane = addr[1:0];
      end else if (ptr_hit) begin
         kind = TGT_PTR;
         idx  = ptr_idx;
         lane = addr[1:0];
      end else if (mem_hit) begin
         kind = TGT_MEM;
         idx  = mem_idx;
         lane = {1'b0, addr[0]};
      end
   end

endmodule

// File: rtl/wdc_narrow.sv
module wdc_narrow
   import wdc_pkg::*;
#(
   parameter int unsigned IDX_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_en,
   input  logic [IDX_W-1:0]  in_idx,
   input  logic [LANE_W-1:0] in_data,
   output logic              nar_we,
   output logic [IDX_W-1:0]  nar_idx,
   output logic [LANE_W-1:0] nar_data
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nar_we   <= 1'b0;
         nar_idx  <= '0;
         nar_data <= '0;
      end else begin
         nar_we <= in_en;
         if (in_en) begin
            nar_idx  <= in_idx;
            nar_data <= in_data;
         end
      end
   end

   a_r2_narrow_forward: assert property (@(posedge clk) disable iff (!rst_n)
      in_en |=> nar_we && nar_data == $past(in_data) && nar_idx == $past(in_idx));

   a_r2_narrow_single: assert property (@(posedge clk) disable iff (!rst_n)
      !in_en |=> !nar_we);

endmodule

// File: rtl/wdc_collect.sv
module wdc_collect
   import wdc_pkg::*;
#(
   parameter int unsigned IDX_W = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      in_en,
   input  tgt_kind_e                 in_kind,
   input  logic [IDX_W-1:0]          in_idx,
   input  logic [1:0]                in_lane,
   input  logic [LANE_W-1:0]         in_data,
   output logic                      cmt_we,
   output logic [1:0]                cmt_kind,
   output logic [IDX_W-1:0]          cmt_idx,
   output logic [LANES*LANE_W-1:0]   cmt_data
);

   // held state
   logic [LANES-1:0]              vmask_q, vmask_d;
   tgt_kind_e                     hkind_q, hkind_d;
   logic [IDX_W-1:0]              hidx_q, hidx_d;
   logic [LANES-1:0][LANE_W-1:0]  hdata_q, hdata_d;

   // commit outputs next state
   logic                          cwe_d;
   logic [1:0]                    ckind_d;
   logic [IDX_W-1:0]              cidx_d;
   logic [LANES*LANE_W-1:0]       cdata_d;

   logic                          coll, busy, same, accept, top_ptr, complete;
   logic [LANES-1:0]              lane_sel, mmask;
   logic [LANES-1:0][LANE_W-1:0]  mdata, fill;

   assign coll     = in_en && (in_kind == TGT_WIDE || in_kind == TGT_PTR || in_kind == TGT_MEM);
   assign busy     = |vmask_q;
   assign same     = busy && (hkind_q == in_kind) && (hidx_q == in_idx);
   assign accept   = coll && (!busy || same);
   assign top_ptr  = coll && (in_kind == TGT_PTR) && (in_lane == 2'd3);
   assign lane_sel = LANES'(1) << in_lane;
   assign mmask    = vmask_q | (accept ? lane_sel : '0);

   // per-lane merge and zero fill
   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         assign mdata[l] = (accept && lane_sel[l]) ? in_data : hdata_q[l];
         assign fill[l]  = mmask[l] ? mdata[l] : '0;
      end
   endgenerate

   always_comb begin
      unique case (in_kind)
         TGT_WIDE: complete = &mmask;
         TGT_MEM:  complete = &mmask[1:0];
         TGT_PTR:  complete = (in_lane == 2'd3);
         default:  complete = 1'b0;
      endcase
   end

   always_comb begin
      vmask_d = vmask_q;
      hkind_d = hkind_q;
      hidx_d  = hidx_q;
      hdata_d = hdata_q;
      cwe_d   = 1'b0;
      ckind_d = cmt_kind;
      cidx_d  = cmt_idx;
      cdata_d = cmt_data;
      if (accept) begin
         if (complete) begin
            cwe_d   = 1'b1;
            ckind_d = commit_code(in_kind);
            cidx_d  = in_idx;
            cdata_d = fill;
            vmask_d = '0;
            hkind_d = TGT_NONE;
         end else begin
            vmask_d = mmask;
            hkind_d = in_kind;
            hidx_d  = in_idx;
            hdata_d = mdata;
         end
      end else if (top_ptr) begin
         cwe_d   = 1'b1;
         ckind_d = CK_PTR;
         cidx_d  = in_idx;
         cdata_d = {in_data, {(LANES-1)*LANE_W{1'b0}}};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vmask_q  <= '0;
         hkind_q  <= TGT_NONE;
         hidx_q   <= '0;
         hdata_q  <= '0;
         cmt_we   <= 1'b0;
         cmt_kind <= CK_WIDE;
         cmt_idx  <= '0;
         cmt_data <= '0;
      end else begin
         vmask_q  <= vmask_d;
         hkind_q  <= hkind_d;
         hidx_q   <= hidx_d;
         hdata_q  <= hdata_d;
         cmt_we   <= cwe_d;
         cmt_kind <= ckind_d;
         cmt_idx  <= cidx_d;
         cmt_data <= cdata_d;
      end
   end

   // R3: a wide commit follows a state with exactly three lanes held
   a_r3_wide_needs_three_held: assert property (@(posedge clk) disable iff (!rst_n)
      cmt_we && cmt_kind == CK_WIDE |-> $countones($past(vmask_q)) == 3);

   // R5: memory words carry nothing above bit 63
   a_r5_mem_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      cmt_we && cmt_kind == CK_MEM |-> cmt_data[127:64] == '0);

   // R7: foreign non-top writes leave the collector alone
   a_r7_foreign_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      coll && busy && !same && !top_ptr |=> $stable(vmask_q) && $stable(hidx_q) && $stable(hdata_q) && !cmt_we);

   // R8: a foreign pointer top write commits and keeps the held lanes
   a_r8_ptr_top_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      top_ptr && busy && !same |=> cmt_we && cmt_kind == CK_PTR && $stable(vmask_q) && $stable(hdata_q));

   // R9: a collected commit leaves the collector empty
   a_r9_empty_after_commit: assert property (@(posedge clk) disable iff (!rst_n)
      cmt_we && !($past(busy) && !$past(same) && $past(top_ptr)) |-> vmask_q == '0);

   // R11: no commit without a write in the previous cycle
   a_r11_strobe_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
      !in_en |=> !cmt_we);

   // R10: memory words never hold the upper lanes
   a_r10_mem_lanes: assert property (@(posedge clk) disable iff (!rst_n)
      hkind_q == TGT_MEM |-> vmask_q[3:2] == 2'b00);

endmodule

// File: rtl/wide_write_collector.sv
module wide_write_collector
   import wdc_pkg::*;
#(
   parameter int unsigned ADDR_W       = 10,
   parameter int unsigned IDX_W        = 4,
   parameter int unsigned NARROW_BASE  = 0,
   parameter int unsigned NARROW_COUNT = 16,
   parameter int unsigned WIDE_BASE    = 64,
   parameter int unsigned WIDE_COUNT   = 4,
   parameter int unsigned PTR_BASE     = 128,
   parameter int unsigned PTR_COUNT    = 4,
   parameter int unsigned MEM_BASE     = 256,
   parameter int unsigned MEM_WORDS    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [31:0]       wr_data,
   output logic              nar_we,
   output logic [IDX_W-1:0]  nar_idx,
   output logic [31:0]       nar_data,
   output logic              cmt_we,
   output logic [1:0]        cmt_kind,
   output logic [IDX_W-1:0]  cmt_idx,
   output logic [127:0]      cmt_data
);

   localparam int unsigned SPACE      = 1 << ADDR_W;
   localparam int unsigned IDX_SPAN   = 1 << IDX_W;
   localparam int unsigned NARROW_END = NARROW_BASE + NARROW_COUNT;
   localparam int unsigned WIDE_END   = WIDE_BASE + LANES * WIDE_COUNT;
   localparam int unsigned PTR_END    = PTR_BASE + LANES * PTR_COUNT;
   localparam int unsigned MEM_END    = MEM_BASE + 2 * MEM_WORDS;

   // elaboration-time parameter checks
   generate
      if (ADDR_W < 2 || ADDR_W > 31) begin : g_bad_addr_w
         $error("ADDR_W must lie in 2..31");
      end
      if (WIDE_BASE % LANES != 0 || PTR_BASE % LANES != 0 || MEM_BASE % 2 != 0) begin : g_bad_align
         $error("wide bases must be aligned to their lane count");
      end
      if (NARROW_COUNT > IDX_SPAN || WIDE_COUNT > IDX_SPAN ||
          PTR_COUNT > IDX_SPAN || MEM_WORDS > IDX_SPAN) begin : g_bad_idx_w
         $error("IDX_W too narrow for a region count");
      end
      if (NARROW_END > SPACE || WIDE_END > SPACE || PTR_END > SPACE || MEM_END > SPACE) begin : g_bad_space
         $error("a region runs past the address space");
      end
      if (spans_overlap(NARROW_BASE, NARROW_END, WIDE_BASE, WIDE_END) ||
          spans_overlap(NARROW_BASE, NARROW_END, PTR_BASE, PTR_END) ||
          spans_overlap(NARROW_BASE, NARROW_END, MEM_BASE, MEM_END) ||
          spans_overlap(WIDE_BASE, WIDE_END, PTR_BASE, PTR_END) ||
          spans_overlap(WIDE_BASE, WIDE_END, MEM_BASE, MEM_END) ||
          spans_overlap(PTR_BASE, PTR_END, MEM_BASE, MEM_END)) begin : g_bad_overlap
         $error("address regions overlap");
      end
   endgenerate

   tgt_kind_e        dec_kind;
   logic [IDX_W-1:0] dec_idx;
   logic [1:0]       dec_lane;

   wdc_decode #(
      .ADDR_W       (ADDR_W),
      .IDX_W        (IDX_W),
      .NARROW_BASE  (NARROW_BASE),
      .NARROW_COUNT (NARROW_COUNT),
      .WIDE_BASE    (WIDE_BASE),
      .WIDE_COUNT   (WIDE_COUNT),
      .PTR_BASE     (PTR_BASE),
      .PTR_COUNT    (PTR_COUNT),
      .MEM_BASE     (MEM_BASE),
      .MEM_WORDS    (MEM_WORDS)
   ) u_decode (
      .addr (wr_addr),
      .kind (dec_kind),
      .idx  (dec_idx),
      .lane (dec_lane)
   );

   wdc_narrow #(
      .IDX_W (IDX_W)
   ) u_narrow (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_en    (wr_en && dec_kind == TGT_NARROW),
      .in_idx   (dec_idx),
      .in_data  (wr_data),
      .nar_we   (nar_we),
      .nar_idx  (nar_idx),
      .nar_data (nar_data)
   );

   wdc_collect #(
      .IDX_W (IDX_W)
   ) u_collect (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_en    (wr_en),
      .in_kind  (dec_kind),
      .in_idx   (dec_idx),
      .in_lane  (dec_lane),
      .in_data  (wr_data),
      .cmt_we   (cmt_we),
      .cmt_kind (cmt_kind),
      .cmt_idx  (cmt_idx),
      .cmt_data (cmt_data)
   );

   // R1: the two strobes never fire for the same write
   a_r1_one_path: assert property (@(posedge clk) disable iff (!rst_n)
      !(nar_we && cmt_we && !$past(cmt_we)));

endmodule

// File: tb/tb_wide_write_collector.sv
module tb_wide_write_collector;

   localparam int AW = 10;
   localparam int IW = 3;
   localparam int NB = 0,   NC = 8;
   localparam int WB = 64,  WC = 3;
   localparam int PB = 128, PC = 2;
   localparam int MB = 256, MW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [31:0]   wr_data = '0;
   logic          nar_we;
   logic [IW-1:0] nar_idx;
   logic [31:0]   nar_data;
   logic          cmt_we;
   logic [1:0]    cmt_kind;
   logic [IW-1:0] cmt_idx;
   logic [127:0]  cmt_data;

   always #5 clk = ~clk;

   wide_write_collector #(
      .ADDR_W (AW), .IDX_W (IW),
      .NARROW_BASE (NB), .NARROW_COUNT (NC),
      .WIDE_BASE (WB), .WIDE_COUNT (WC),
      .PTR_BASE (PB), .PTR_COUNT (PC),
      .MEM_BASE (MB), .MEM_WORDS (MW)
   ) dut (
      .clk (clk), .rst_n (rst_n),
      .wr_en (wr_en), .wr_addr (wr_addr), .wr_data (wr_data),
      .nar_we (nar_we), .nar_idx (nar_idx), .nar_data (nar_data),
      .cmt_we (cmt_we), .cmt_kind (cmt_kind), .cmt_idx (cmt_idx), .cmt_data (cmt_data)
   );

   int    n_chk = 0;
   int    n_fail = 0;
   string phase = "R10";

   // reference model: kinds 0 none, 1 narrow, 2 wide, 3 pointer, 4 memory
   int          m_mask, m_kind, m_idx;
   logic [31:0] m_dw [4];
   bit          e_nwe, e_cwe;
   int          e_nidx, e_ckind, e_cidx;
   logic [31:0] e_ndata;
   logic [127:0] e_cdata;

   function automatic void dec(input int a, output int k, output int i, output int d);
      k = 0; i = 0; d = 0;
      if (a >= NB && a < NB + NC) begin k = 1; i = a - NB; end
      else if (a >= WB && a < WB + 4*WC) begin k = 2; i = (a - WB) / 4; d = (a - WB) % 4; end
      else if (a >= PB && a < PB + 4*PC) begin k = 3; i = (a - PB) / 4; d = (a - PB) % 4; end
      else if (a >= MB && a < MB + 2*MW) begin k = 4; i = (a - MB) / 2; d = (a - MB) % 2; end
   endfunction

   always @(posedge clk) begin
      int  k, i, d;
      bit  busy, same, done;
      if (!rst_n) begin
         m_mask = 0; m_kind = 0; m_idx = 0;
         e_nwe = 0; e_cwe = 0;
      end else begin
         e_nwe = 0; e_cwe = 0;
         if (wr_en) begin
            dec(int'(wr_addr), k, i, d);
            if (k == 1) begin
               e_nwe = 1; e_nidx = i; e_ndata = wr_data;
            end else if (k >= 2) begin
               busy = (m_mask != 0);
               same = busy && m_kind == k && m_idx == i;
               if (!busy || same) begin
                  m_dw[d] = wr_data;
                  m_mask = m_mask | (1 << d);
                  m_kind = k; m_idx = i;
                  done = (k == 2 && m_mask == 15) || (k == 4 && (m_mask & 3) == 3) || (k == 3 && d == 3);
                  if (done) begin
                     e_cwe = 1; e_ckind = k - 2; e_cidx = i;
                     for (int l = 0; l < 4; l++)
                        e_cdata[l*32 +: 32] = ((m_mask >> l) & 1) ? m_dw[l] : 32'h0;
                     m_mask = 0; m_kind = 0;
                  end
               end else if (k == 3 && d == 3) begin
                  e_cwe = 1; e_ckind = 1; e_cidx = i;
                  e_cdata = {wr_data, 96'h0};
               end
            end
         end
      end
   end

   task automatic fail_line(input string what, input logic [127:0] act, input logic [127:0] exp);
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", phase, what, act, exp);
   endtask

   task automatic model_check();
      bit bad = 0;
      n_chk++;
      if (nar_we !== e_nwe) begin bad = 1; fail_line("nar_we", 128'(nar_we), 128'(e_nwe)); end
      else if (e_nwe && (nar_idx !== IW'(e_nidx) || nar_data !== e_ndata)) begin
         bad = 1; fail_line("nar idx/data", {nar_idx, nar_data}, {IW'(e_nidx), e_ndata});
      end
      if (!bad) begin
         if (cmt_we !== e_cwe) fail_line("cmt_we", 128'(cmt_we), 128'(e_cwe));
         else if (e_cwe && (cmt_kind !== 2'(e_ckind) || cmt_idx !== IW'(e_cidx)))
            fail_line("cmt kind/idx", {cmt_kind, cmt_idx}, {2'(e_ckind), IW'(e_cidx)});
         else if (e_cwe && cmt_data !== e_cdata) fail_line("cmt_data", cmt_data, e_cdata);
      end
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      model_check();
   endtask

   task automatic idle();
      @(negedge clk);
      model_check();
   endtask

   task automatic expect_commit(input bit we, input int kind, input int idx,
                                input logic [127:0] data, input string tag);
      n_chk++;
      if (cmt_we !== we || (we && (cmt_kind !== 2'(kind) || cmt_idx !== IW'(idx) || cmt_data !== data))) begin
         n_fail++;
         $display("FAIL %s: actual we=%0b kind=%0d idx=%0d data=%h expected we=%0b kind=%0d idx=%0d data=%h",
                  tag, cmt_we, cmt_kind, cmt_idx, cmt_data, we, kind, idx, data);
      end
   endtask

   bit finished = 0;

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      // R10: reset state
      repeat (3) @(negedge clk);
      n_chk++;
      if (nar_we !== 1'b0 || cmt_we !== 1'b0) begin
         n_fail++;
         $display("FAIL R10 reset strobes: actual %0b%0b expected 00", nar_we, cmt_we);
      end
      rst_n = 1'b1;
      idle();

      // R1, R2: narrow pass-through and unmapped addresses
      phase = "R2";
      wr(NB + 0, 32'h1111_0000);
      wr(NB + 7, 32'h7777_0007);
      phase = "R1";
      wr(40, 32'hDEAD_0040);
      expect_commit(0, 0, 0, '0, "R1 unmapped write");
      wr(1000, 32'hDEAD_1000);
      idle();

      // R3: wide register 1, lanes in order 2,0,3,1
      phase = "R3";
      wr(WB + 4 + 2, 32'hA2A2_A2A2);
      wr(WB + 4 + 0, 32'hA0A0_A0A0);
      wr(WB + 4 + 3, 32'hA3A3_A3A3);
      expect_commit(0, 0, 0, '0, "R3 no commit before fourth lane");
      wr(WB + 4 + 1, 32'hA1A1_A1A1);
      expect_commit(1, 0, 1, {32'hA3A3_A3A3, 32'hA2A2_A2A2, 32'hA1A1_A1A1, 32'hA0A0_A0A0}, "R3 wide commit");
      // R11: idle after commit
      phase = "R11";
      idle();
      expect_commit(0, 0, 0, '0, "R11 strobe single cycle");

      // R4: rewrite of a held lane
      phase = "R4";
      wr(WB + 0, 32'h0000_00AA);
      wr(WB + 0, 32'h0000_00BB);
      wr(WB + 1, 32'h0000_0011);
      wr(WB + 2, 32'h0000_0022);
      wr(WB + 3, 32'h0000_0033);
      expect_commit(1, 0, 0, {32'h33, 32'h22, 32'h11, 32'hBB}, "R4 overwrite held lane");

      // R5: memory word 3, high lane first
      phase = "R5";
      wr(MB + 7, 32'hC1C1_C1C1);
      wr(MB + 6, 32'hC0C0_C0C0);
      expect_commit(1, 2, 3, {64'h0, 32'hC1C1_C1C1, 32'hC0C0_C0C0}, "R5 memory commit");

      // R6: pointer register zero fill
      phase = "R6";
      wr(PB + 4 + 0, 32'hD0D0_D0D0);
      wr(PB + 4 + 2, 32'hD2D2_D2D2);
      wr(PB + 4 + 3, 32'hD3D3_D3D3);
      expect_commit(1, 1, 1, {32'hD3D3_D3D3, 32'hD2D2_D2D2, 32'h0, 32'hD0D0_D0D0}, "R6 pointer partial fill");
      wr(PB + 3, 32'hE3E3_E3E3);
      expect_commit(1, 1, 0, {32'hE3E3_E3E3, 96'h0}, "R6 pointer top only");

      // R7: interleaved writers never tear
      phase = "R7";
      wr(WB + 8 + 0, 32'hF0F0_F0F0);
      wr(WB + 0, 32'h0BAD_0000);
      wr(PB + 4 + 1, 32'h0BAD_0001);
      wr(MB + 0, 32'h0BAD_0002);
      wr(WB + 8 + 1, 32'hF1F1_F1F1);
      wr(WB + 8 + 2, 32'hF2F2_F2F2);
      wr(WB + 8 + 3, 32'hF3F3_F3F3);
      expect_commit(1, 0, 2, {32'hF3F3_F3F3, 32'hF2F2_F2F2, 32'hF1F1_F1F1, 32'hF0F0_F0F0}, "R7 no torn commit");

      // R8: foreign pointer top write while busy
      phase = "R8";
      wr(WB + 4 + 0, 32'h5050_5050);
      wr(PB + 3, 32'h8383_8383);
      expect_commit(1, 1, 0, {32'h8383_8383, 96'h0}, "R8 foreign pointer top");
      wr(WB + 4 + 1, 32'h5151_5151);
      wr(WB + 4 + 2, 32'h5252_5252);
      wr(WB + 4 + 3, 32'h5353_5353);
      expect_commit(1, 0, 1, {32'h5353_5353, 32'h5252_5252, 32'h5151_5151, 32'h5050_5050}, "R8 held lanes kept");

      // R9: collector empty right after commit
      phase = "R9";
      wr(MB + 2, 32'h9090_9090);
      wr(MB + 3, 32'h9191_9191);
      expect_commit(1, 2, 1, {64'h0, 32'h9191_9191, 32'h9090_9090}, "R9 accepted after commit");

      // R7: random traffic against the model
      phase = "R7 random";
      for (int n = 0; n < 600; n++) begin
         int sel = $urandom_range(0, 9);
         int a;
         if (sel < 4)      a = WB + $urandom_range(0, 4*WC - 1);
         else if (sel < 7) a = PB + $urandom_range(0, 4*PC - 1);
         else if (sel < 9) a = MB + $urandom_range(0, 2*MW - 1);
         else              a = NB + $urandom_range(0, NC - 1);
         if ($urandom_range(0, 5) == 0) idle();
         else wr(a, $urandom);
      end
      idle();

      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule